// File: doc/BRIEF.md
# Cascaded Serial DAC Load Sequencer

This block is the host side of a cascade of identical 12-bit serial DACs. The devices share one serial clock line and one frame-sync line. The data input of each device is fed from the serial output of the device before it. All devices also share a load strobe. When a start request arrives, the sequencer captures one 12-bit value per device and runs one complete write. It drops sync, shifts a 16-bit frame for every device using a serial clock derived from the system clock, raises sync, and then pulses the load strobe low so that every converter output changes at the same moment.

Each frame holds four padding bits sent as zeros, followed by the 12-bit value MSB first. The device nearest the host captures the most recent frame. For that reason the frames go out starting with the device at the far end of the chain. Timing is set by three parameters: the number of devices, the serial clock half-period in system clocks, and the load strobe width in system clocks. Data changes on the rising serial clock edge so that it is settled at the falling edge, where the devices sample it. A busy flag covers the whole transaction, and a one-cycle done flag closes it.

Top module: `daisy_dac_seq`

## Requirements
- R1: After reset the serial clock, sync and load outputs are high, serial data is low, and busy and done are low.
- R2: A transaction lowers sync, produces exactly 16×NUM_DEV falling serial clock edges while sync is low, and then raises sync.
- R3: Value field d of `chan_vals_i` (bits d*12+11 down to d*12) reaches device d, where device 0 is the one wired directly to the host. Frames are therefore sent for device NUM_DEV-1 first and device 0 last.
- R4: Every 16-bit frame starts with four zero bits, followed by the 12 value bits from MSB to LSB.
- R5: While sync is low, serial data changes only in the system clock cycle in which the serial clock rises, so it is stable at every falling edge.
- R6: During a burst, each low phase and each high phase of the serial clock, including the final high phase before sync rises, lasts HALF_DIV system clocks.
- R7: Sync falls while the serial clock is high, and it falls exactly HALF_DIV system clocks before the first falling serial clock edge.
- R8: The load strobe goes low exactly one system clock after sync returns high and stays low for STROBE_W system clocks. It is never low while sync is low.
- R9: Done is high for exactly one system clock, in the cycle after the load strobe returns high. Busy is low in that cycle.
- R10: A start request made while busy has no effect. The transaction in progress delivers its own captured values, and no further transaction follows.
- R11: The serial clock stays high whenever sync is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| chan_vals_i | input | NUM_DEV*12 | One 12-bit value per device, device 0 in the low bits |
| busy_o | output | 1 | High from the accepted start until the strobe completes |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |
| dac_sclk_o | output | 1 | Serial clock to the chain, idles high |
| dac_sdata_o | output | 1 | Serial data to the first device |
| dac_sync_n_o | output | 1 | Active-low frame sync |
| dac_load_n_o | output | 1 | Active-low load strobe |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a burst. If it were not ignored, it would corrupt the shift order, and the mistake would only show up once all devices had latched their values. To reach it, the bench starts one transaction, waits until the serial clock is partway through the frames, and then pulses start with a different set of values. A behavioural model of the cascade shifts on every falling serial clock edge and latches on the load strobe. The bench reads the latched values back from this model and checks them against the first value set. It also checks that exactly one strobe occurred and that busy stays low afterwards.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int FRAME_W = 16;
    localparam int PAD_W   = 4;
    localparam int VAL_W   = FRAME_W - PAD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_REL,
        ST_PRE,
        ST_STB,
        ST_FIN
    } dcs_state_e;
endpackage

// File: rtl/dcs_pace.sv
// Phase timer: counts system clocks since the last restart and flags the
// final cycle of a phase whose length is given by limit_i.
module dcs_pace #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = restart_i ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/dcs_bitsel.sv
// Picks the serial bit for a given frame index and bit position.
// Frame 0 carries the farthest device's value.
module dcs_bitsel
    import dcs_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int WW      = 2
) (
    input  logic [NUM_DEV*VAL_W-1:0] vals_i,
    input  logic [WW-1:0]            word_i,
    input  logic [3:0]               bit_i,
    output logic                     bit_o
);
    logic [3:0] pos;

    always_comb begin
        pos   = 4'(FRAME_W - 1) - bit_i;
        bit_o = 1'b0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (word_i == WW'(NUM_DEV - 1 - d) && bit_i >= 4'(PAD_W)) begin
                bit_o = vals_i[d*VAL_W + int'(pos)];
            end
        end
    end
endmodule

// File: rtl/daisy_dac_seq.sv
module daisy_dac_seq
    import dcs_pkg::*;
#(
    parameter int NUM_DEV  = 3,
    parameter int HALF_DIV = 10,
    parameter int STROBE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_DEV*VAL_W-1:0] chan_vals_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     dac_sclk_o,
    output logic                     dac_sdata_o,
    output logic                     dac_sync_n_o,
    output logic                     dac_load_n_o
);
    localparam int WW    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int MAXPH = (HALF_DIV > STROBE_W) ? HALF_DIV : STROBE_W;
    localparam int CW    = $clog2(MAXPH + 1);

    typedef struct packed {
        dcs_state_e               st;
        logic [WW-1:0]            word;
        logic [3:0]               bitn;
        logic [NUM_DEV*VAL_W-1:0] vals;
        logic                     sclk;
        logic                     sync_n;
        logic                     load_n;
        logic                     sdata;
        logic                     done;
    } regs_t;

    regs_t r_d, r_q;

    logic          expire;
    logic          restart;
    logic [CW-1:0] limit;
    logic [WW-1:0] adv_word;
    logic [3:0]    adv_bit;
    logic          sel_bit;
    logic          last_bit;

    dcs_pace #(.CW(CW)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .limit_i  (limit),
        .expire_o (expire)
    );

    dcs_bitsel #(.NUM_DEV(NUM_DEV), .WW(WW)) u_bitsel (
        .vals_i(r_q.vals),
        .word_i(adv_word),
        .bit_i (adv_bit),
        .bit_o (sel_bit)
    );

    always_comb begin
        // Next bit position within the burst.
        if (r_q.bitn == 4'(FRAME_W - 1)) begin
            adv_bit  = '0;
            adv_word = r_q.word + 1'b1;
        end else begin
            adv_bit  = r_q.bitn + 1'b1;
            adv_word = r_q.word;
        end
        last_bit = (r_q.word == WW'(NUM_DEV - 1)) && (r_q.bitn == 4'(FRAME_W - 1));
        limit    = (r_q.st == ST_STB) ? CW'(STROBE_W) : CW'(HALF_DIV);

        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (start_i) begin
                r_d.st     = ST_LEAD;
                r_d.vals   = chan_vals_i;
                r_d.word   = '0;
                r_d.bitn   = '0;
                r_d.sync_n = 1'b0;
                r_d.sdata  = 1'b0;   // first bit is padding
            end
            ST_LEAD: if (expire) begin
                r_d.sclk = 1'b0;
                r_d.st   = ST_LOW;
            end
            ST_LOW: if (expire) begin
                r_d.sclk = 1'b1;
                if (last_bit) begin
                    r_d.st = ST_REL;
                end else begin
                    r_d.word  = adv_word;
                    r_d.bitn  = adv_bit;
                    r_d.sdata = sel_bit;
                    r_d.st    = ST_HIGH;
                end
            end
            ST_HIGH: if (expire) begin
                r_d.sclk = 1'b0;
                r_d.st   = ST_LOW;
            end
            ST_REL: if (expire) begin
                r_d.sync_n = 1'b1;
                r_d.sdata  = 1'b0;
                r_d.st     = ST_PRE;
            end
            ST_PRE: begin
                r_d.load_n = 1'b0;
                r_d.st     = ST_STB;
            end
            ST_STB: if (expire) begin
                r_d.load_n = 1'b1;
                r_d.st     = ST_FIN;
            end
            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        restart = (r_d.st != r_q.st) || (r_q.st == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.sclk   <= 1'b1;
            r_q.sync_n <= 1'b1;
            r_q.load_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign dac_sclk_o   = r_q.sclk;
    assign dac_sdata_o  = r_q.sdata;
    assign dac_sync_n_o = r_q.sync_n;
    assign dac_load_n_o = r_q.load_n;
endmodule

// File: rtl/dcs_seq_chk.sv
module dcs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic dac_sclk_o,
    input logic dac_sdata_o,
    input logic dac_sync_n_o,
    input logic dac_load_n_o
);
    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n_o |-> dac_sclk_o); // R11
    AST_STROBE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n_o |-> (dac_sync_n_o && $past(dac_sync_n_o))); // R8
    AST_SYNC_FALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sync_n_o) |-> (dac_sclk_o && dac_load_n_o)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sync_n_o) |-> !$past(busy_o)); // R10
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk_o) |-> $stable(dac_sdata_o)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (dac_load_n_o && $past(dac_load_n_o) && !$past(dac_load_n_o, 2))); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
endmodule

bind daisy_dac_seq dcs_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .dac_sclk_o  (dac_sclk_o),
    .dac_sdata_o (dac_sdata_o),
    .dac_sync_n_o(dac_sync_n_o),
    .dac_load_n_o(dac_load_n_o)
);

// File: tb/daisy_dac_seq_test.sv
module daisy_dac_seq_test;
    localparam int N  = 3;
    localparam int H  = 10;
    localparam int S  = 5;
    localparam int VW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N*VW-1:0] vals = '0;
    logic busy, done, sclk, sdata, sync_n, load_n;

    always #5 clk = ~clk;

    daisy_dac_seq #(.NUM_DEV(N), .HALF_DIV(H), .STROBE_W(S)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_vals_i(vals),
        .busy_o(busy), .done_o(done), .dac_sclk_o(sclk), .dac_sdata_o(sdata),
        .dac_sync_n_o(sync_n), .dac_load_n_o(load_n)
    );

    // Behavioural cascade: device 0 takes the host data, its frame MSB feeds the next.
    logic [16*N-1:0] chain = '0;
    logic [16*N-1:0] latched = '0;
    always @(negedge sclk) if (!sync_n) chain <= {chain[16*N-2:0], sdata};
    always @(negedge load_n) latched <= chain;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit reported = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            report();
        end
    end

    // Port monitor, sampled mid-cycle.
    logic p_sclk = 1, p_sync = 1, p_load = 1, p_sdata = 0, p_done = 0;
    int run = 0, lead_cnt = 0, lead_last = 0, falls = 0, falls_last = 0;
    int sync_rise_cyc = 0, load_fall_gap = 0, load_w = 0, load_w_last = 0;
    int load_rise_cyc = 0, done_gap = 0, load_pulses = 0;
    int err_width = 0, err_data = 0, err_idle = 0, err_loadsync = 0, err_done = 0;
    bit first_fall = 0;

    always @(negedge clk) if (rst_n) begin
        if (p_sync && !sync_n) begin
            falls = 0; first_fall = 0; lead_cnt = 0;
            if (!load_n) err_loadsync++;
        end
        if (!sync_n && !first_fall && sclk) lead_cnt++;
        if (sclk != p_sclk) begin
            if (!sync_n && first_fall && run != H) err_width++;
            if (!sclk && !sync_n) begin
                if (!first_fall) lead_last = lead_cnt;
                first_fall = 1;
                falls++;
            end
            run = 1;
        end else run++;
        if (!p_sync && !sync_n && sdata != p_sdata && !(sclk && !p_sclk)) err_data++;
        if (!p_sync && sync_n) begin
            if (first_fall && run - 1 != H) err_width++;
            sync_rise_cyc = cyc;
            falls_last = falls;
        end
        if (sync_n && !sclk) err_idle++;
        if (p_load && !load_n) begin
            if (!sync_n) err_loadsync++;
            load_fall_gap = cyc - sync_rise_cyc;
            load_pulses++;
            load_w = 0;
        end
        if (!load_n) begin
            load_w++;
            if (!sync_n) err_loadsync++;
        end
        if (!p_load && load_n) begin
            load_w_last = load_w;
            load_rise_cyc = cyc;
        end
        if (done) begin
            if (p_done) err_done++;
            done_gap = cyc - load_rise_cyc;
            if (busy) err_done++;
        end
        p_sclk = sclk; p_sync = sync_n; p_load = load_n; p_sdata = sdata; p_done = done;
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic pulse_start(input logic [N*VW-1:0] v);
        @(negedge clk);
        vals  = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_result(input logic [N*VW-1:0] v, input string tag);
        for (int d = 0; d < N; d++) begin
            chk(latched[16*d +: VW] == v[VW*d +: VW], {"R3 device value ", tag},
                int'(latched[16*d +: VW]), int'(v[VW*d +: VW]));
            chk(latched[16*d+12 +: 4] == 4'h0, {"R4 padding zero ", tag},
                int'(latched[16*d+12 +: 4]), 0);
        end
        chk(falls_last == 16*N, {"R2 falling edge count ", tag}, falls_last, 16*N);
        chk(err_width == 0, {"R6 half period ", tag}, err_width, 0);
        chk(err_data == 0, {"R5 data change point ", tag}, err_data, 0);
        chk(lead_last == H, {"R7 sync lead ", tag}, lead_last, H);
        chk(load_w_last == S, {"R8 strobe width ", tag}, load_w_last, S);
        chk(load_fall_gap == 1, {"R8 strobe after sync ", tag}, load_fall_gap, 1);
        chk(err_loadsync == 0, {"R8 strobe vs sync ", tag}, err_loadsync, 0);
        chk(done_gap == 1, {"R9 done timing ", tag}, done_gap, 1);
        chk(err_done == 0, {"R9 done pulse ", tag}, err_done, 0);
        chk(err_idle == 0, {"R11 idle clock ", tag}, err_idle, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sclk && sync_n && load_n && !sdata && !busy && !done, "R1 reset levels",
            {26'd0, sclk, sync_n, load_n, sdata, busy, done}, 6'b111000);
    endtask

    task automatic t_txn(input logic [N*VW-1:0] v, input string tag);
        pulse_start(v);
        chk(busy && !sync_n, {"R2 busy and sync low ", tag}, {busy, sync_n}, 2'b10);
        wait_done();
        chk(!busy && sync_n, {"R9 idle at done ", tag}, {busy, sync_n}, 2'b01);
        repeat (3) @(negedge clk);
        check_result(v, tag);
    endtask

    task automatic t_ignored();
        logic [N*VW-1:0] first_v = {12'h123, 12'h456, 12'h789};
        int pulses0;
        pulses0 = load_pulses;
        pulse_start(first_v);
        repeat (200) @(negedge clk);
        vals  = {12'hFED, 12'hCBA, 12'h987};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk(!busy && sync_n, "R10 no second transaction", {busy, sync_n}, 2'b01);
        chk(load_pulses == pulses0 + 1, "R10 one strobe", load_pulses - pulses0, 1);
        check_result(first_v, "ignored start");
    endtask

    task automatic t_back_to_back();
        pulse_start({12'h001, 12'h800, 12'h7FF});
        wait_done();
        vals  = {12'hA5C, 12'h3E1, 12'h0F0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2 restart at done", busy, 1);
        wait_done();
        repeat (3) @(negedge clk);
        check_result({12'hA5C, 12'h3E1, 12'h0F0}, "back to back");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_txn({12'hA5C, 12'h3E1, 12'h0F0}, "distinct");
        t_txn({N{12'hFFF}}, "all ones");
        t_txn({N{12'h000}}, "all zero");
        t_txn({12'h001, 12'h800, 12'h7FF}, "edges");
        t_ignored();
        t_back_to_back();
        report();
    end
endmodule